// File: doc/BRIEF.md
# Ring Stop Injection Arbiter

This block is one stop on a unidirectional ring of stops. Every cycle a flit slot arrives at the ring input. The slot holds a valid bit, a destination stop id and a payload. The slot leaves through a one-cycle pipeline register at the ring output. The stop compares the destination with its own fixed id. A matching flit is taken off the ring into a small local delivery FIFO. A freed or empty slot can be filled by a flit waiting in the local send queue.

Through traffic always keeps its slot, so a local flit waits until the slot is free. A flit for this stop that cannot be stored because the delivery FIFO is full is not held back. It stays in its slot, goes round the ring again (a bounce), and a bounce counter records it. Because of this, flits to one stop may arrive in a different order from the one they were sent in. A local flit addressed to the stop itself never enters the ring. It is written straight into the delivery FIFO.

Top module: `ring_stop_arbiter`

## Requirements
- R1: A valid ring flit whose destination differs from NODE_ID appears on the ring output in the next cycle, with the same destination and payload.
- R2: When the ring input slot is empty and a local flit for another stop is offered, injTaken is high in that cycle and the flit appears on the ring output in the next cycle.
- R3: A valid ring flit that is not ejected keeps the slot: injTaken stays low for a local flit bound for another stop, and the ring output carries the ring flit in the next cycle.
- R4: A ring flit whose destination equals NODE_ID is written into the delivery FIFO when the FIFO is not full. With no local flit offered, the ring output is invalid in the next cycle.
- R5: In a cycle where a ring flit is ejected, a local flit for another stop is injected in that same cycle (injTaken high) and is on the ring output in the next cycle.
- R6: A ring flit for NODE_ID that arrives while the FIFO is full is on the ring output in the next cycle with its destination and payload unchanged, and bounceCount rises by one. bounceCount wraps at its width.
- R7: A local flit whose destination equals NODE_ID never goes onto the ring. It is written into the FIFO (injTaken high) when the FIFO is not full and no ring flit is being ejected in that cycle; through traffic on the ring does not block it. Otherwise it waits with injTaken low.
- R8: The delivery FIFO returns payloads in the order they were written. ejValid is high while it holds data, and ejData shows the oldest entry. ejPop removes that entry at the clock edge. The FIFO counts as full when it holds EJ_DEPTH entries before that cycle's pop, so a pop in the same cycle does not make room for that cycle's arrival.
- R9: After reset the ring output is invalid, the FIFO is empty (ejValid low) and bounceCount is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringInValid | input | 1 | Ring input slot is occupied |
| ringInDest | input | ID_W | Destination stop id of ring input flit |
| ringInData | input | PAY_W | Payload of ring input flit |
| ringOutValid | output | 1 | Registered ring output slot occupied |
| ringOutDest | output | ID_W | Destination of ring output flit |
| ringOutData | output | PAY_W | Payload of ring output flit |
| injValid | input | 1 | Local send queue offers a flit |
| injDest | input | ID_W | Destination of the offered local flit |
| injData | input | PAY_W | Payload of the offered local flit |
| injTaken | output | 1 | Offered local flit accepted this cycle |
| ejValid | output | 1 | Delivery FIFO holds at least one entry |
| ejData | output | PAY_W | Oldest payload in the delivery FIFO |
| ejPop | input | 1 | Remove the oldest delivery FIFO entry |
| bounceCount | output | CNT_W | Number of bounced flits, wrapping |

## Verification
Each wrong internal decision in this block shows at the ports within one cycle. A wrong pass, eject or inject choice puts the wrong flit, or no flit, on the registered ring output at the next edge. It also makes injTaken wrong in the same cycle. Corrupted FIFO pointers or a wrong count show only when entries are popped: payloads come out in the wrong order, ejValid drops too early, or a flit bounces when it should have been stored. The bounce counter is visible directly, so a missed or doubled increment is seen one cycle after the bouncing flit.

// File: rtl/ring_stop_pkg.sv
package ring_stop_pkg;

  typedef struct packed {
    logic passRing;
    logic ejectRing;
    logic injectRing;
    logic selfDeliver;
    logic bounce;
  } stopStrobes_t;

endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import ring_stop_pkg::*;
#(
  parameter int ID_W    = 3,
  parameter int NODE_ID = 1
) (
  input  logic            ringInValid,
  input  logic [ID_W-1:0] ringInDest,
  input  logic            injValid,
  input  logic [ID_W-1:0] injDest,
  input  logic            fifoFull,
  output stopStrobes_t    strobes
);

  localparam logic [ID_W-1:0] MyId = ID_W'(NODE_ID);

  logic ringMatch;
  logic injSelf;
  logic slotFree;

  always_comb begin
    ringMatch = ringInValid && (ringInDest == MyId);
    injSelf   = (injDest == MyId);

    strobes.ejectRing   = ringMatch && !fifoFull;
    strobes.bounce      = ringMatch && fifoFull;
    strobes.passRing    = ringInValid && !strobes.ejectRing;
    slotFree            = !strobes.passRing;
    strobes.injectRing  = injValid && !injSelf && slotFree;
    strobes.selfDeliver = injValid && injSelf && !fifoFull && !strobes.ejectRing;
  end

endmodule

// File: rtl/rs_eject_fifo.sv
module rs_eject_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic         full,
  output logic         notEmpty,
  output logic [W-1:0] headData
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LastIdx = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FullCnt = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          popEff;
  logic          pushEff;

  assign full     = (count == FullCnt);
  assign notEmpty = (count != '0);
  assign headData = mem[rdPtr];
  assign popEff   = pop && notEmpty;
  assign pushEff  = push && !full;

  always_ff @(posedge clk) begin
    if (pushEff) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushEff) wrPtr <= (wrPtr == LastIdx) ? '0 : wrPtr + 1'b1;
      if (popEff)  rdPtr <= (rdPtr == LastIdx) ? '0 : rdPtr + 1'b1;
      case ({pushEff, popEff})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: no write is ever attempted into a full FIFO
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);

  // R8: a pop on a non-empty FIFO without a push lowers occupancy
  p_pop_drains_r8: assert property (@(posedge clk) disable iff (!rstN)
    (popEff && !pushEff) |=> !full);

endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import ring_stop_pkg::*;
#(
  parameter int ID_W     = 3,
  parameter int PAY_W    = 16,
  parameter int EJ_DEPTH = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stopStrobes_t     strobes,
  input  logic             ringInValid,
  input  logic [ID_W-1:0]  ringInDest,
  input  logic [PAY_W-1:0] ringInData,
  input  logic [ID_W-1:0]  injDest,
  input  logic [PAY_W-1:0] injData,
  input  logic             ejPop,
  output logic             ringOutValid,
  output logic [ID_W-1:0]  ringOutDest,
  output logic [PAY_W-1:0] ringOutData,
  output logic             fifoFull,
  output logic             ejValid,
  output logic [PAY_W-1:0] ejData,
  output logic [CNT_W-1:0] bounceCount
);

  logic             fifoPush;
  logic [PAY_W-1:0] fifoPushData;

  assign fifoPush     = strobes.ejectRing || strobes.selfDeliver;
  assign fifoPushData = strobes.ejectRing ? ringInData : injData;

  rs_eject_fifo #(.W(PAY_W), .DEPTH(EJ_DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (fifoPush),
    .pushData (fifoPushData),
    .pop      (ejPop),
    .full     (fifoFull),
    .notEmpty (ejValid),
    .headData (ejData)
  );

  // ring latch stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringOutValid <= 1'b0;
      ringOutDest  <= '0;
      ringOutData  <= '0;
    end else if (strobes.passRing) begin
      ringOutValid <= 1'b1;
      ringOutDest  <= ringInDest;
      ringOutData  <= ringInData;
    end else if (strobes.injectRing) begin
      ringOutValid <= 1'b1;
      ringOutDest  <= injDest;
      ringOutData  <= injData;
    end else begin
      ringOutValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               bounceCount <= '0;
    else if (strobes.bounce) bounceCount <= bounceCount + 1'b1;
  end

  // R1: passing traffic leaves one cycle later unchanged
  p_pass_latch_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.passRing |=> ringOutValid && ringOutDest == $past(ringInDest)
                         && ringOutData == $past(ringInData));

  // R6: a bounce keeps the flit on the ring and counts once
  p_bounce_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bounce |=> ringOutValid && bounceCount == CNT_W'($past(bounceCount) + 1'b1));

  // R6: the counter moves only on a bounce
  p_count_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.bounce |=> $stable(bounceCount));

  // R1: a valid input flit is either stored in the FIFO or kept on the ring
  p_no_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ringInValid && !fifoPush) |=> ringOutValid);

endmodule

// File: rtl/ring_stop_arbiter.sv
module ring_stop_arbiter
  import ring_stop_pkg::*;
#(
  parameter int ID_W     = 3,
  parameter int NODE_ID  = 1,
  parameter int PAY_W    = 16,
  parameter int EJ_DEPTH = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ringInValid,
  input  logic [ID_W-1:0]  ringInDest,
  input  logic [PAY_W-1:0] ringInData,
  output logic             ringOutValid,
  output logic [ID_W-1:0]  ringOutDest,
  output logic [PAY_W-1:0] ringOutData,
  input  logic             injValid,
  input  logic [ID_W-1:0]  injDest,
  input  logic [PAY_W-1:0] injData,
  output logic             injTaken,
  output logic             ejValid,
  output logic [PAY_W-1:0] ejData,
  input  logic             ejPop,
  output logic [CNT_W-1:0] bounceCount
);

  localparam logic [ID_W-1:0] MyId = ID_W'(NODE_ID);

  stopStrobes_t strobes;
  logic         fifoFull;

  rs_ctrl #(.ID_W(ID_W), .NODE_ID(NODE_ID)) u_ctrl (
    .ringInValid (ringInValid),
    .ringInDest  (ringInDest),
    .injValid    (injValid),
    .injDest     (injDest),
    .fifoFull    (fifoFull),
    .strobes     (strobes)
  );

  rs_datapath #(
    .ID_W(ID_W), .PAY_W(PAY_W), .EJ_DEPTH(EJ_DEPTH), .CNT_W(CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .ringInValid  (ringInValid),
    .ringInDest   (ringInDest),
    .ringInData   (ringInData),
    .injDest      (injDest),
    .injData      (injData),
    .ejPop        (ejPop),
    .ringOutValid (ringOutValid),
    .ringOutDest  (ringOutDest),
    .ringOutData  (ringOutData),
    .fifoFull     (fifoFull),
    .ejValid      (ejValid),
    .ejData       (ejData),
    .bounceCount  (bounceCount)
  );

  assign injTaken = strobes.injectRing || strobes.selfDeliver;

  // R3: through traffic is never displaced by a local flit
  p_ring_priority_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ringInValid && ringInDest != MyId && injDest != MyId) |-> !injTaken);

  // R5: an ejected slot is reused by a waiting local flit in the same cycle
  p_eject_frees_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ringInValid && ringInDest == MyId && !fifoFull && injValid && injDest != MyId)
      |-> injTaken);

  // R7: a self-addressed local flit never reaches the ring output
  p_self_off_ring_r7: assert property (@(posedge clk) disable iff (!rstN)
    (injTaken && injDest == MyId) |=> !(ringOutValid && ringOutDest == MyId));

  // R2: an empty slot with a waiting remote-bound flit is filled
  p_fill_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ringInValid && injValid && injDest != MyId) |-> injTaken);

endmodule

// File: tb/sim_ring_stop_arbiter.sv
`timescale 1ns/1ps
module sim_ring_stop_arbiter;

  localparam int ID_W = 3, NODE_ID = 1, PAY_W = 16, EJ_DEPTH = 4, CNT_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic ringInValid = 1'b0; logic [ID_W-1:0] ringInDest = '0; logic [PAY_W-1:0] ringInData = '0;
  logic injValid = 1'b0;    logic [ID_W-1:0] injDest = '0;    logic [PAY_W-1:0] injData = '0;
  logic ejPop = 1'b0;
  logic ringOutValid, injTaken, ejValid;
  logic [ID_W-1:0] ringOutDest;
  logic [PAY_W-1:0] ringOutData, ejData;
  logic [CNT_W-1:0] bounceCount;

  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;  // 50 MHz

  ring_stop_arbiter #(.ID_W(ID_W), .NODE_ID(NODE_ID), .PAY_W(PAY_W),
                      .EJ_DEPTH(EJ_DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN),
    .ringInValid(ringInValid), .ringInDest(ringInDest), .ringInData(ringInData),
    .ringOutValid(ringOutValid), .ringOutDest(ringOutDest), .ringOutData(ringOutData),
    .injValid(injValid), .injDest(injDest), .injData(injData), .injTaken(injTaken),
    .ejValid(ejValid), .ejData(ejData), .ejPop(ejPop), .bounceCount(bounceCount)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle of inputs at the falling edge; combinational outputs settle by +5ns
  task automatic drive(input logic rv, input logic [ID_W-1:0] rd, input logic [PAY_W-1:0] rdat,
                       input logic iv, input logic [ID_W-1:0] idst, input logic [PAY_W-1:0] idat,
                       input logic pop);
    @(negedge clk);
    ringInValid = rv; ringInDest = rd; ringInData = rdat;
    injValid = iv; injDest = idst; injData = idat; ejPop = pop;
    #5;
  endtask

  // pass the rising edge and settle registered outputs
  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic idle();
    drive(1'b0, '0, '0, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic t_reset();
    check("R9 ring out invalid", ringOutValid, 1'b0);
    check("R9 fifo empty", ejValid, 1'b0);
    check("R9 bounce count zero", bounceCount, 0);
  endtask

  task automatic t_pass();
    drive(1'b1, 3'd2, 16'h1111, 1'b1, 3'd4, 16'h9999, 1'b0);
    check("R3 local waits behind ring", injTaken, 1'b0);
    tick();
    check("R1 pass valid", ringOutValid, 1'b1);
    check("R1 pass dest", ringOutDest, 3'd2);
    check("R1 pass data", ringOutData, 16'h1111);
  endtask

  task automatic t_inject();
    drive(1'b0, '0, '0, 1'b1, 3'd3, 16'h2222, 1'b0);
    check("R2 inject taken", injTaken, 1'b1);
    tick();
    check("R2 inject valid", ringOutValid, 1'b1);
    check("R2 inject dest", ringOutDest, 3'd3);
    check("R2 inject data", ringOutData, 16'h2222);
  endtask

  task automatic t_eject();
    drive(1'b1, 3'd1, 16'hA001, 1'b0, '0, '0, 1'b0);
    tick();
    check("R4 slot empty after eject", ringOutValid, 1'b0);
    check("R4 fifo has data", ejValid, 1'b1);
    check("R4 head data", ejData, 16'hA001);
  endtask

  task automatic t_eject_inject();
    drive(1'b1, 3'd1, 16'hB002, 1'b1, 3'd0, 16'hC003, 1'b0);
    check("R5 inject on freed slot", injTaken, 1'b1);
    tick();
    check("R5 ring out valid", ringOutValid, 1'b1);
    check("R5 ring out dest", ringOutDest, 3'd0);
    check("R5 ring out data", ringOutData, 16'hC003);
  endtask

  task automatic t_self();
    drive(1'b0, '0, '0, 1'b1, 3'd1, 16'hD004, 1'b0);
    check("R7 self flit taken", injTaken, 1'b1);
    tick();
    check("R7 self flit not on ring", ringOutValid, 1'b0);
    // self delivery alongside through traffic
    drive(1'b1, 3'd5, 16'h5555, 1'b1, 3'd1, 16'hE005, 1'b0);
    check("R7 self flit beside through traffic", injTaken, 1'b1);
    tick();
    check("R7 through flit kept", ringOutData, 16'h5555);
    check("R7 through dest kept", ringOutDest, 3'd5);
  endtask

  task automatic t_bounce();
    // FIFO now holds four entries: full
    drive(1'b1, 3'd1, 16'hF006, 1'b1, 3'd1, 16'h7777, 1'b0);
    check("R7 self flit waits when full", injTaken, 1'b0);
    tick();
    check("R6 bounced valid", ringOutValid, 1'b1);
    check("R6 bounced dest", ringOutDest, 3'd1);
    check("R6 bounced data", ringOutData, 16'hF006);
    check("R6 count one", bounceCount, 1);
    // pop in same cycle as arrival while full: still bounces
    drive(1'b1, 3'd1, 16'h0A07, 1'b0, '0, '0, 1'b1);
    tick();
    check("R8 pop does not admit same cycle", ringOutData, 16'h0A07);
    check("R6 count two", bounceCount, 2);
    idle();
    tick();
    check("R6 count stable", bounceCount, 2);
  endtask

  task automatic t_drain();
    logic [PAY_W-1:0] expOrder [3] = '{16'hB002, 16'hD004, 16'hE005};
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, '0, '0, 1'b0, '0, '0, 1'b1);
      check("R8 valid during drain", ejValid, 1'b1);
      check("R8 order", ejData, expOrder[k]);
      tick();
    end
    idle();
    check("R8 empty after drain", ejValid, 1'b0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #5;
    t_reset();
    @(negedge clk); rstN = 1'b1;
    t_pass();
    t_inject();
    t_eject();
    t_eject_inject();
    t_self();
    t_bounce();
    t_drain();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule